// File: doc/BRIEF.md
# One-Wire ROM Search Pass Engine

This block runs the per-bit work of one pass through the 64-bit ROM search tree on a one-wire bus. The host has already sent the search command byte over the normal bus master. It then raises a mode input and hands over one byte for each group of four ROM bit positions. In that byte, the path bit for each position sits on an odd data bit. For each position the block performs three bus slots. The first reads the ROM bit. The second reads its complement. The third writes back the chosen branch. When all four positions of the byte are done, the block returns a byte holding the chosen bits on the odd positions and the discrepancy flags on the even positions.

A complete pass takes sixteen such exchanges, lowest nibble first. From the returned discrepancy flags, host software works out the path for the next pass. The slot timing stays in the existing bus master. This block only issues one slot request at a time, with the value to drive (1 for a read slot), and takes the sampled bus level back when the slot completes. Dropping the mode input ends the search and abandons any exchange in progress.

Top module: `ow_search_accel`

## Requirements
- R1: A byte offered on `tx_valid` is accepted only while `srch_mode` is 1 and `busy` is 0. An offer while `srch_mode` is 0 starts no slot and leaves `busy` at 0.
- R2: For each accepted byte the block processes 4 positions, k = 0 first and k = 3 last. Each position uses three slots in this order: read (drive 1), read complement (drive 1), write chosen bit. Each slot is one `slot_start` pulse, and the block waits for `slot_done` before the next slot.
- R3: The path bit for position k is `tx_byte[2k+1]`. The even bits of `tx_byte` have no effect.
- R4: If both reads return 0, the discrepancy flag is 1 and the written bit equals the path bit.
- R5: If the two reads differ, the written bit equals the first read value and the discrepancy flag is 0.
- R6: If both reads return 1 (no responder), the chosen bit and the discrepancy flag are both 1, and the written bit is 1.
- R7: In `rx_byte`, bit 2k+1 holds the chosen bit of position k and bit 2k holds its discrepancy flag.
- R8: `rx_full` rises in the cycle after the write slot of position 3 completes. It stays low while earlier positions complete. `rx_take` clears it.
- R9: Clearing `srch_mode` abandons the exchange. `busy` is 0 one cycle later, no further `slot_start` is issued, and `rx_full` is not set.
- R10: After reset, `busy`, `rx_full`, `rx_byte` and `slot_start` are 0.
- R11: A `tx_valid` offer while `busy` is 1 is ignored, and the exchange in progress keeps its original path bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srch_mode | input | 1 | Search mode enable; clearing it leaves the mode |
| tx_valid | input | 1 | One-cycle offer of a path byte |
| tx_byte | input | 8 | Path byte, path bit k at bit 2k+1 |
| busy | output | 1 | An exchange is in progress |
| rx_byte | output | 8 | Result byte, chosen bit k at 2k+1, discrepancy k at 2k |
| rx_full | output | 1 | Result byte ready |
| rx_take | input | 1 | Clears `rx_full` |
| slot_start | output | 1 | Request one bus slot |
| slot_wbit | output | 1 | Level to drive in the requested slot |
| slot_done | input | 1 | Requested slot has completed |
| slot_rbit | input | 1 | Bus level sampled in the completed slot |

## Verification
Any fault in the slot phase or in the position counter shows up at `slot_wbit` within the next slot. Examples are a write slot issued where a read belongs, or the wrong path bit selected. A wrongly latched read value or discrepancy decision changes `rx_byte` at the end of the same exchange, four positions at most later. A position counter that wraps early or late moves the rise of `rx_full` by whole slots. Faults in mode handling appear as a `slot_start` pulse or a high `busy` in the cycle after the mode input drops.

// File: rtl/ow_search_accel.sv
module ow_search_accel #(
  parameter int POS_PER_XFER = 4,
  localparam int XW = 2 * POS_PER_XFER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srch_mode,
  input  logic          tx_valid,
  input  logic [XW-1:0] tx_byte,
  output logic          busy,
  output logic [XW-1:0] rx_byte,
  output logic          rx_full,
  input  logic          rx_take,
  output logic          slot_start,
  output logic          slot_wbit,
  input  logic          slot_done,
  input  logic          slot_rbit
);
  localparam int PW = $clog2(POS_PER_XFER);
  localparam logic [1:0] PH_READ = 2'd0, PH_COMP = 2'd1, PH_WRITE = 2'd2;

  logic                    busy_q, pend_q, first_q, chosen_q, disc_q;
  logic [1:0]              phase_q;
  logic [PW-1:0]           pos_q;
  logic [POS_PER_XFER-1:0] path_q;
  logic [XW-1:0]           res_q, res_nx;
  logic                    last_pos;

  assign busy       = busy_q;
  assign slot_start = busy_q & ~pend_q & srch_mode;
  assign slot_wbit  = (phase_q == PH_WRITE) ? chosen_q : 1'b1;
  assign last_pos   = (pos_q == PW'(POS_PER_XFER - 1));

  always_comb begin
    res_nx = res_q;
    res_nx[{pos_q, 1'b1}] = chosen_q;
    res_nx[{pos_q, 1'b0}] = disc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      phase_q  <= PH_READ;
      pos_q    <= '0;
      path_q   <= '0;
      first_q  <= 1'b0;
      chosen_q <= 1'b0;
      disc_q   <= 1'b0;
      res_q    <= '0;
      rx_byte  <= '0;
      rx_full  <= 1'b0;
    end else begin
      if (rx_take) rx_full <= 1'b0;
      if (!srch_mode) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (!busy_q) begin
        if (tx_valid) begin
          busy_q  <= 1'b1;
          pend_q  <= 1'b0;
          phase_q <= PH_READ;
          pos_q   <= '0;
          res_q   <= '0;
          for (int k = 0; k < POS_PER_XFER; k++) path_q[k] <= tx_byte[2*k+1];
        end
      end else if (slot_start) begin
        pend_q <= 1'b1;
      end else if (slot_done) begin
        pend_q <= 1'b0;
        case (phase_q)
          PH_READ: begin
            first_q <= slot_rbit;
            phase_q <= PH_COMP;
          end
          PH_COMP: begin
            phase_q <= PH_WRITE;
            if (!first_q && !slot_rbit) begin
              chosen_q <= path_q[pos_q];
              disc_q   <= 1'b1;
            end else if (first_q && slot_rbit) begin
              chosen_q <= 1'b1;
              disc_q   <= 1'b1;
            end else begin
              chosen_q <= first_q;
              disc_q   <= 1'b0;
            end
          end
          default: begin
            phase_q <= PH_READ;
            res_q   <= res_nx;
            if (last_pos) begin
              busy_q  <= 1'b0;
              rx_byte <= res_nx;
              rx_full <= 1'b1;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start);

  // R9
  mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_mode |=> !busy);

  // R8
  full_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(slot_done && busy && srch_mode));

  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(rx_take));

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(srch_mode && tx_valid));

endmodule

// File: tb/ow_search_accel_tb.sv
module ow_search_accel_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       srch_mode = 1'b0, tx_valid = 1'b0, rx_take = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       slot_done = 1'b0, slot_rbit = 1'b0;
  logic       busy, rx_full, slot_start, slot_wbit;
  logic [7:0] rx_byte;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ow_search_accel dut_i (
    .clk(clk), .rst_n(rst_n), .srch_mode(srch_mode), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .busy(busy), .rx_byte(rx_byte), .rx_full(rx_full),
    .rx_take(rx_take), .slot_start(slot_start), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] decide(input bit a, input bit b, input bit p);
    if (!a && !b) return {p, 1'b1};
    if (a && b)   return 2'b11;
    return {a, 1'b0};
  endfunction

  task automatic serve_slot(input bit exp_w, input bit rbit, input bit inject, input string req);
    int guard = 0;
    while (!slot_start && guard < 50) begin @(negedge clk); guard++; end
    chk(slot_start == 1'b1, "R2 slot_start seen", slot_start, 1);
    chk(slot_wbit == exp_w, req, slot_wbit, exp_w);
    @(negedge clk);
    if (inject) begin tx_valid = 1'b1; tx_byte = ~tx_byte; end
    repeat ($urandom_range(0, 2)) @(negedge clk);
    tx_valid = 1'b0;
    slot_done = 1'b1; slot_rbit = rbit;
    @(negedge clk);
    slot_done = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] txb, input logic [7:0] ab, input bit inject);
    logic [7:0] exp;
    logic [1:0] cd;
    rx_take = 1'b1; @(negedge clk); rx_take = 1'b0;
    tx_byte = txb; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    exp = 8'h00;
    for (int k = 0; k < 4; k++) begin
      cd = decide(ab[2*k+1], ab[2*k], txb[2*k+1]);
      serve_slot(1'b1, ab[2*k+1], inject && k == 1, "R2 first read drives 1");
      serve_slot(1'b1, ab[2*k], 1'b0, "R2 complement read drives 1");
      serve_slot(cd[1], 1'b0, 1'b0, "R4/R5/R6 written bit");
      exp[2*k+1] = cd[1];
      exp[2*k]   = cd[0];
      if (k < 3) chk(rx_full == 1'b0, "R8 rx_full low before last position", rx_full, 0);
    end
    chk(rx_full == 1'b1, "R8 rx_full after position 3", rx_full, 1);
    chk(rx_byte == exp, "R7 result byte (R3 path, R11 ignore)", rx_byte, exp);
    chk(busy == 1'b0, "R2 idle after 4 positions", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10 busy reset", busy, 0);
    chk(rx_full == 0, "R10 rx_full reset", rx_full, 0);
    chk(rx_byte == 0, "R10 rx_byte reset", rx_byte, 0);
    chk(slot_start == 0, "R10 slot_start reset", slot_start, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: offer outside the mode
    tx_byte = 8'hAA; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(slot_start == 0 && busy == 0, "R1 no slot outside mode", {busy, slot_start}, 0);
      @(negedge clk);
    end

    srch_mode = 1'b1;
    @(negedge clk);
    // directed: R4 conflicts with path 1 then path 0 (even bits set, R3)
    xfer(8'hAA, 8'h00, 1'b0);
    xfer(8'h55, 8'h00, 1'b0);
    // R6 all no responder
    xfer(8'h00, 8'hFF, 1'b0);
    // R5 all differ, both orders
    xfer(8'hFF, 8'h66, 1'b0);
    xfer(8'h0F, 8'h99, 1'b1);

    // random mix, R11 injections
    for (int n = 0; n < 40; n++)
      xfer(8'($urandom), 8'($urandom), 1'($urandom_range(0, 1)));

    // R9: abort mid-exchange
    rx_take = 1'b1; @(negedge clk); rx_take = 1'b0;
    tx_byte = 8'h80; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    serve_slot(1'b1, 1'b0, 1'b0, "R2 read before abort");
    serve_slot(1'b1, 1'b0, 1'b0, "R2 comp before abort");
    srch_mode = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R9 busy dropped", busy, 0);
    for (int i = 0; i < 6; i++) begin
      chk(slot_start == 0, "R9 no slot after exit", slot_start, 0);
      chk(rx_full == 0, "R9 rx_full not set", rx_full, 0);
      @(negedge clk);
    end
    srch_mode = 1'b1;
    @(negedge clk);
    xfer(8'h02, 8'h00, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule